// File: doc/BRIEF.md
# Addressed Bus Read Responder

This block is a read-only slave on a shared data bus. It watches an address bus and a read strobe and compares the address with its own address, which comes in on an input. When a read is requested at its own address, it samples an internal data word into a private holding register on that clock edge. From the next cycle it drives the held word onto the shared bus, and it keeps doing so for as long as the read strobe stays high.

At every other time the block releases all bus lines to high impedance, so other agents can use the bus. The word is captured once per read. A change of the source word or of the address during a read therefore has no effect on what the bus carries. The control is a two-state machine (waiting and sending). The datapath holds an equality comparator, the holding register with a load enable, and a bus driver with an output enable.

Top module: `bus_read_slave`

## Requirements
- R1: While reset is active, and until the first cycle after it is released, the data bus is high impedance on every bit, whatever the strobe and address inputs are.
- R2: In the waiting state with `rd_req` low, the data bus stays high impedance for any address, including the block's own address.
- R3: In the waiting state with `rd_req` high and `addr_bus` not equal to `own_addr`, the data bus stays high impedance and the block remains waiting.
- R4: In the waiting state, `rd_req` high with `addr_bus` equal to `own_addr` at a rising clock edge loads `src_data` into the holding register on that edge. From the next cycle the bus carries that value.
- R5: While sending with `rd_req` high, the bus keeps the captured value, and changes of `src_data` do not reach it.
- R6: While sending with `rd_req` high, changes of `addr_bus` do not end the read and do not change the driven value.
- R7: `rd_req` sampled low while sending returns the block to waiting, and the bus is high impedance from the next cycle.
- R8: A later read at the own address captures the `src_data` value present at that read's start edge, not the value of an earlier read.
- R9: The match compares all address bits against the `own_addr` input. An address that differs only in its most significant bit does not match. A new `own_addr` value takes effect at the next edge. A read strobe that was already high on a mismatching address starts a read once the address matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req | input | 1 | Read strobe, high for the length of a read |
| addr_bus | input | AW (4) | Address presented on the bus |
| own_addr | input | AW (4) | Address this slave answers to |
| src_data | input | DW (32) | Internal word offered for reading |
| data_bus | output | DW (32) | Shared data bus, high impedance unless a read is being served |

## Verification
The bench runs the strobe at the own address during reset and in the idle state, and runs it high on foreign addresses. This separates a responder that decodes both conditions from one that reacts to only one of them. During a served read it changes the source word and then the address, which shows whether the word was latched once or passes straight through. It runs a second read with a new word, an address that differs only in its top bit, and a new own address with the strobe held high across the match. These separate a fresh capture from a stale one and a full-width compare from a partial one.

// File: rtl/rdslv_pkg.sv
package rdslv_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_SEND = 1'b1
  } rdslv_state_e;
endpackage

// File: rtl/rdslv_addr_cmp.sv
module rdslv_addr_cmp #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          equal
);
  logic [AW-1:0] bit_same;

  for (genvar g = 0; g < AW; g++) begin : g_bit
    assign bit_same[g] = ~(addr_a[g] ^ addr_b[g]);
  end

  assign equal = &bit_same;
endmodule

// File: rtl/rdslv_ctrl.sv
module rdslv_ctrl
  import rdslv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic addr_hit,
  output logic hold_ld,
  output logic drv_en
);
  rdslv_state_e state_q, state_d;
  logic         req_hit;

  assign req_hit = rd_req & addr_hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT: if (req_hit) state_d = ST_SEND;
      ST_SEND: if (!rd_req) state_d = ST_WAIT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  assign hold_ld = (state_q == ST_WAIT) & req_hit;
  assign drv_en  = (state_q == ST_SEND);
endmodule

// File: rtl/rdslv_hold_reg.sv
module rdslv_hold_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bus_read_slave.sv
module bus_read_slave #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] addr_bus,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] src_data,
  output logic [DW-1:0] data_bus
);
  localparam logic [DW-1:0] BUS_RELEASE = {DW{1'bz}};

  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_int_n;
  logic                       addr_hit;
  logic                       hold_ld;
  logic                       drv_en;
  logic [DW-1:0]              hold_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_SYNC_STAGES-1];

  rdslv_addr_cmp #(.AW(AW)) u_cmp (
    .addr_a (addr_bus),
    .addr_b (own_addr),
    .equal  (addr_hit)
  );

  rdslv_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_req   (rd_req),
    .addr_hit (addr_hit),
    .hold_ld  (hold_ld),
    .drv_en   (drv_en)
  );

  rdslv_hold_reg #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (hold_ld),
    .d     (src_data),
    .q     (hold_q)
  );

  assign data_bus = drv_en ? hold_q : BUS_RELEASE;
endmodule

// File: rtl/rdslv_chk.sv
module rdslv_chk #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          rd_req,
  input logic [AW-1:0] addr_bus,
  input logic [AW-1:0] own_addr,
  input logic [DW-1:0] src_data,
  input logic          drv_en,
  input logic [DW-1:0] hold_q
);
  always @(posedge clk) begin
    if (!rst_int_n) begin
      AST_RESET_RELEASED: assert (!drv_en); // R1
    end
  end

  AST_FOREIGN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!drv_en && !(rd_req && addr_bus == own_addr)) |=> !drv_en); // R3

  AST_MATCH_CAPTURES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!drv_en && rd_req && addr_bus == own_addr) |=> (drv_en && hold_q == $past(src_data))); // R4

  AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (drv_en && rd_req) |=> (drv_en && $stable(hold_q))); // R5

  AST_STROBE_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (drv_en && !rd_req) |=> !drv_en); // R7
endmodule

bind bus_read_slave rdslv_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .rd_req    (rd_req),
  .addr_bus  (addr_bus),
  .own_addr  (own_addr),
  .src_data  (src_data),
  .drv_en    (drv_en),
  .hold_q    (hold_q)
);

// File: tb/test_bus_read_slave.sv
`timescale 1ns/1ps
module test_bus_read_slave;
  localparam int AW = 4;
  localparam int DW = 32;

  typedef struct {
    logic          want_z;
    logic [DW-1:0] want_val;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_req;
  logic [AW-1:0] addr_bus;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] src_data;
  wire  [DW-1:0] data_bus;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;

  bus_read_slave #(.AW(AW), .DW(DW)) i_bus_read_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .addr_bus (addr_bus),
    .own_addr (own_addr),
    .src_data (src_data),
    .data_bus (data_bus)
  );

  // driver: apply inputs away from the edge, expect the bus after the next edge
  task automatic step(input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] s,
                      input logic wz, input logic [DW-1:0] wv, input string tag);
    exp_t e;
    @(negedge clk);
    rd_req   = rd;
    addr_bus = a;
    src_data = s;
    e.want_z   = wz;
    e.want_val = wv;
    e.tag      = tag;
    exp_q.push_back(e);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (e.want_z) begin
          if (data_bus !== {DW{1'bz}}) begin
            n_fail++;
            $display("FAIL %s: bus=%h expected=%h", e.tag, data_bus, {DW{1'bz}});
          end
        end else if (data_bus !== e.want_val) begin
          n_fail++;
          $display("FAIL %s: bus=%h expected=%h", e.tag, data_bus, e.want_val);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [DW-1:0] ZV = '0;

  initial begin
    rst_n    = 1'b0;
    rd_req   = 1'b0;
    addr_bus = '0;
    own_addr = 4'hA;
    src_data = '0;
    // R1: strobe at own address during reset, bus must stay released
    step(1'b1, 4'hA, 32'h1111_2222, 1'b1, ZV, "R1 reset");
    step(1'b1, 4'hA, 32'h1111_2222, 1'b1, ZV, "R1 reset");
    step(1'b0, 4'hA, 32'h1111_2222, 1'b1, ZV, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R2: idle, strobe low, any address
    step(1'b0, 4'hA, 32'hDEAD_BEEF, 1'b1, ZV, "R2 idle own addr");
    step(1'b0, 4'h3, 32'hDEAD_BEEF, 1'b1, ZV, "R2 idle other addr");
    step(1'b0, 4'hA, 32'hDEAD_BEEF, 1'b1, ZV, "R2 idle own addr");
    // R3: strobe on foreign addresses
    step(1'b1, 4'h3, 32'hCAFE_0001, 1'b1, ZV, "R3 foreign read");
    step(1'b1, 4'h0, 32'hCAFE_0002, 1'b1, ZV, "R3 foreign read");
    step(1'b1, 4'h2, 32'hCAFE_0003, 1'b1, ZV, "R9 msb-only difference");
    // R4: matching read captures
    step(1'b1, 4'hA, 32'h1234_5678, 1'b0, 32'h1234_5678, "R4 capture");
    // R5: source changes ignored
    step(1'b1, 4'hA, 32'h8765_4321, 1'b0, 32'h1234_5678, "R5 source change");
    // R6: address changes ignored
    step(1'b1, 4'h3, 32'h0F0F_0F0F, 1'b0, 32'h1234_5678, "R6 address change");
    // R7: strobe low releases
    step(1'b0, 4'h3, 32'h0F0F_0F0F, 1'b1, ZV, "R7 release");
    step(1'b0, 4'hA, 32'h0F0F_0F0F, 1'b1, ZV, "R7 stays released");
    // R8: second read picks up a fresh word
    step(1'b1, 4'hA, 32'hA5A5_5A5A, 1'b0, 32'hA5A5_5A5A, "R8 fresh capture");
    step(1'b1, 4'hA, 32'h0000_0000, 1'b0, 32'hA5A5_5A5A, "R8 held");
    step(1'b0, 4'hA, 32'h0000_0000, 1'b1, ZV, "R8 release");
    // R9: new own address, strobe held high across the match
    @(negedge clk);
    own_addr = 4'h5;
    step(1'b1, 4'hA, 32'h5555_0001, 1'b1, ZV, "R9 old address no longer matches");
    step(1'b1, 4'h5, 32'h5555_0002, 1'b0, 32'h5555_0002, "R9 new address matches");
    step(1'b0, 4'h5, 32'h5555_0003, 1'b1, ZV, "R9 release");
    step(1'b0, 4'h5, 32'h5555_0003, 1'b1, ZV, "R2 idle after read");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule